// File: doc/BRIEF.md
# Lane Test Pattern Generator

This block sits just ahead of a serializer and decides, on every symbol clock, which 10-bit symbol each of four lanes carries. With the bypass control low it passes either the normal link data or one of four externally supplied link training codes, chosen by a latched index. A training-complete flag decides between the two. With bypass high it emits test content in its place. For each lane that content is either a pseudo-random bit sequence (PRBS7 or PRBS23) or a repeating run of eight programmable raw 10-bit symbols.

The eight symbols can be written one at a time, or all at once from an 80-bit custom pattern given as ten bytes. The bytes are repacked into 10-bit symbols. Loading 0x2AA into every symbol gives the D10.2 clock-like pattern. Writes made while test content is on the lanes are staged. They reach the lanes only when the symbol sequence wraps back to symbol 0, so the output never shows a half-updated pattern.

Top module: `lane_test_patgen`

## Requirements
- R1: After reset, with bypass low, every lane carries training code 0 (bits 9:0 of `train_codes`) and `train_done` is 0.
- R2: With bypass low and `train_done` high, lane k carries bits 10k+9:10k of `norm_data` in the same cycle.
- R3: A `train_wr` pulse latches `train_sel` as the training index and clears `train_done` from the next cycle on. With bypass low and `train_done` low, every lane carries code n (bits 10n+9:10n of `train_codes`). `train_done_set` sets the flag, and `train_wr` wins when both are high.
- R4: With bypass high, a lane whose bit in `lane_dbg_sel` is 1 carries debug symbol i in the i-th cycle after bypass rises, counting from 0. The index wraps from 7 to 0 and restarts at 0 each time bypass rises.
- R5: `cust_load` takes byte b from bits 8b+7:8b of `cust_pat`. Symbol 0 gets byte0 in bits 7:0 and byte1 bits 1:0 in bits 9:8. Symbol 1 gets byte1 bits 7:2 in bits 5:0 and byte2 bits 3:0 in bits 9:6. Symbol 2 gets byte2 bits 7:4 in bits 3:0 and byte3 bits 5:0 in bits 9:4. Symbol 3 gets byte3 bits 7:6 in bits 1:0 and byte4 in bits 9:2. Symbols 4 to 7 repeat the same scheme on bytes 5 to 9. `cust_load` has priority over a single-symbol write in the same cycle.
- R6: While bypass is high, symbol writes and custom loads change no lane output until the cycle in which symbol 0 next appears. With bypass low they are visible as soon as bypass rises.
- R7: With `prbs_en` 1 and `prbs_sel` 0, a PRBS lane carries PRBS7 (x^7+x^6+1). The 7-bit state starts as all ones, each new bit is state[6]^state[5] and is shifted into bit 0, and ten bits are produced per cycle with the first bit in bit 0 of the symbol.
- R8: With `prbs_sel` 1, a PRBS lane carries PRBS23 (x^23+x^18+1). The 23-bit state starts as all ones, each new bit is state[22]^state[17], and the ordering is the same as in R7.
- R9: While `prbs_en` is 0, a PRBS lane carries 0 in bypass and both generators hold their all-ones seed, so re-enabling restarts each sequence from its beginning.
- R10: The PRBS or debug choice is made per lane: lanes with select 1 show debug symbols while lanes with select 0 show PRBS in the same cycle.
- R11: With all eight symbols loaded with 0x2AA, every debug lane carries 0x2AA in every bypass cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_en | input | 1 | 1 puts test content on the lanes |
| prbs_en | input | 1 | Runs the PRBS generators |
| prbs_sel | input | 1 | 0 selects PRBS7, 1 selects PRBS23 |
| lane_dbg_sel | input | 4 | Per lane: 1 debug symbols, 0 PRBS |
| sym_wr | input | 1 | Write one debug symbol |
| sym_wr_idx | input | 3 | Symbol written |
| sym_wr_data | input | 10 | Symbol value |
| cust_load | input | 1 | Load all symbols from `cust_pat` |
| cust_pat | input | 80 | Ten bytes, byte b at bits 8b+7:8b |
| train_wr | input | 1 | Latch training index, clear done flag |
| train_sel | input | 2 | Training index 0..3 |
| train_done_set | input | 1 | Set the training-complete flag |
| train_codes | input | 40 | Four training symbols, code n at bits 10n+9:10n |
| norm_data | input | 40 | Normal lane data, lane k at bits 10k+9:10k |
| lane_sym | output | 40 | Lane symbols, lane k at bits 10k+9:10k |
| train_done | output | 1 | Training-complete flag |

## Verification
The embedded properties are checked on every cycle. They cover the restart of the symbol index on a bypass rise and its single-step advance, the freezing of the active symbol bank between wraps, the clearing of the done flag after a training write, the pass-through of normal data, and a silent PRBS lane while its generator is off. The exact PRBS7 and PRBS23 bit streams, the byte-to-symbol repacking, and the visible moment at which a staged write appears can only be shown by the bench. It steps its own model of the requirements alongside the design and compares every lane on every cycle.

// File: rtl/lane_test_patgen.sv
module lane_test_patgen #(
  parameter int LANES   = 4,
  parameter int SYM_W   = 10,
  parameter int NSYM    = 8,
  parameter int TRAIN_N = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bypass_en,
  input  logic                     prbs_en,
  input  logic                     prbs_sel,
  input  logic [LANES-1:0]         lane_dbg_sel,
  input  logic                     sym_wr,
  input  logic [$clog2(NSYM)-1:0]  sym_wr_idx,
  input  logic [SYM_W-1:0]         sym_wr_data,
  input  logic                     cust_load,
  input  logic [NSYM*SYM_W-1:0]    cust_pat,
  input  logic                     train_wr,
  input  logic [$clog2(TRAIN_N)-1:0] train_sel,
  input  logic                     train_done_set,
  input  logic [TRAIN_N*SYM_W-1:0] train_codes,
  input  logic [LANES*SYM_W-1:0]   norm_data,
  output logic [LANES*SYM_W-1:0]   lane_sym,
  output logic                     train_done
);
  localparam int IDX_W  = $clog2(NSYM);
  localparam int TSEL_W = $clog2(TRAIN_N);
  localparam int P7_N   = 7;
  localparam int P23_N  = 23;

  logic [NSYM-1:0][SYM_W-1:0]    stg_q, stg_d, act_q;
  logic [NSYM-1:0][SYM_W-1:0]    cust_v;
  logic [TRAIN_N-1:0][SYM_W-1:0] tcodes;
  logic [IDX_W-1:0]  idx_q;
  logic [TSEL_W-1:0] tidx_q;
  logic              done_q;
  logic [P7_N-1:0]   p7_q, p7_d;
  logic [P23_N-1:0]  p23_q, p23_d;
  logic [SYM_W-1:0]  p7_w, p23_w, prbs_w, dbg_w, train_w;
  logic              wrap;

  assign cust_v = cust_pat;
  assign tcodes = train_codes;
  assign wrap   = idx_q == IDX_W'(NSYM - 1);

  always_comb begin
    for (int i = 0; i < NSYM; i++) begin
      if (cust_load)
        stg_d[i] = cust_v[i];
      else if (sym_wr && sym_wr_idx == IDX_W'(i))
        stg_d[i] = sym_wr_data;
      else
        stg_d[i] = stg_q[i];
    end
  end

  always_comb begin
    p7_d  = p7_q;
    p23_d = p23_q;
    for (int b = 0; b < SYM_W; b++) begin
      p7_w[b]  = p7_d[6] ^ p7_d[5];
      p7_d     = {p7_d[P7_N-2:0], p7_w[b]};
      p23_w[b] = p23_d[22] ^ p23_d[17];
      p23_d    = {p23_d[P23_N-2:0], p23_w[b]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_q  <= '0;
      act_q  <= '0;
      idx_q  <= '0;
      tidx_q <= '0;
      done_q <= 1'b0;
      p7_q   <= '1;
      p23_q  <= '1;
    end else begin
      stg_q <= stg_d;
      if (!bypass_en || wrap) act_q <= stg_d;
      idx_q <= (bypass_en && !wrap) ? idx_q + IDX_W'(1) : '0;
      if (prbs_en) begin
        p7_q  <= p7_d;
        p23_q <= p23_d;
      end else begin
        p7_q  <= '1;
        p23_q <= '1;
      end
      if (train_wr) begin
        tidx_q <= train_sel;
        done_q <= 1'b0;
      end else if (train_done_set) begin
        done_q <= 1'b1;
      end
    end
  end

  assign dbg_w      = act_q[idx_q];
  assign prbs_w     = !prbs_en ? '0 : (prbs_sel ? p23_w : p7_w);
  assign train_w    = tcodes[tidx_q];
  assign train_done = done_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_sym[l*SYM_W +: SYM_W] =
      bypass_en ? (lane_dbg_sel[l] ? dbg_w : prbs_w)
                : (done_q ? norm_data[l*SYM_W +: SYM_W] : train_w);
  end

  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass_en) |-> idx_q == '0);

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_en && $past(bypass_en) && !$past(wrap)) |-> idx_q == $past(idx_q) + IDX_W'(1));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bypass_en && !wrap) |-> $stable(act_q));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    train_wr |=> !train_done);

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass_en && train_done) |-> lane_sym == norm_data);

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_en && !prbs_en && !lane_dbg_sel[0]) |-> lane_sym[SYM_W-1:0] == '0);
endmodule

// File: tb/sim_lane_test_patgen.sv
module sim_lane_test_patgen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bypass_en = 1'b0, prbs_en = 1'b0, prbs_sel = 1'b0;
  logic [3:0] lane_dbg_sel = '0;
  logic sym_wr = 1'b0;
  logic [2:0] sym_wr_idx = '0;
  logic [9:0] sym_wr_data = '0;
  logic cust_load = 1'b0;
  logic [79:0] cust_pat = '0;
  logic train_wr = 1'b0;
  logic [1:0] train_sel = '0;
  logic train_done_set = 1'b0;
  logic [39:0] train_codes = {10'h17C, 10'h0F8, 10'h2B5, 10'h14A};
  logic [39:0] norm_data = '0;
  logic [39:0] lane_sym;
  logic train_done;

  lane_test_patgen u0 (.*);

  always #2 clk = ~clk;

  typedef struct { int cyc; int lane; logic [9:0] exp; string req; } item_t;
  item_t q[$];
  item_t cur;
  int cyc_n = 0, n_run = 0, n_fail = 0;
  always @(posedge clk) cyc_n <= cyc_n + 1;

  logic [7:0][9:0] m_stg = '0, m_act = '0;
  logic [2:0] m_idx = '0;
  logic [6:0] m7 = '1;
  logic [22:0] m23 = '1;
  logic m_done = 1'b0;
  logic [1:0] m_tidx = '0;
  logic [7:0] cb [10];

  function automatic logic [16:0] adv7(input logic [6:0] s0);
    logic [6:0] s = s0; logic [9:0] w; logic b;
    for (int k = 0; k < 10; k++) begin b = s[6] ^ s[5]; w[k] = b; s = {s[5:0], b}; end
    return {w, s};
  endfunction

  function automatic logic [32:0] adv23(input logic [22:0] s0);
    logic [22:0] s = s0; logic [9:0] w; logic b;
    for (int k = 0; k < 10; k++) begin b = s[22] ^ s[17]; w[k] = b; s = {s[21:0], b}; end
    return {w, s};
  endfunction

  // R5 packing written out symbol by symbol
  function automatic logic [7:0][9:0] pack_custom();
    logic [7:0][9:0] r;
    for (int h = 0; h < 2; h++) begin
      r[4*h+0] = {cb[5*h+1][1:0], cb[5*h+0]};
      r[4*h+1] = {cb[5*h+2][3:0], cb[5*h+1][7:2]};
      r[4*h+2] = {cb[5*h+3][5:0], cb[5*h+2][7:4]};
      r[4*h+3] = {cb[5*h+4],      cb[5*h+3][7:6]};
    end
    return r;
  endfunction

  task automatic cyc(input string tag);
    logic [16:0] r7; logic [32:0] r23; logic [9:0] pw, dw, e; logic [7:0][9:0] ns;
    r7 = adv7(m7); r23 = adv23(m23);
    pw = !prbs_en ? 10'h0 : (prbs_sel ? r23[32:23] : r7[16:7]);
    dw = m_act[m_idx];
    for (int l = 0; l < 4; l++) begin
      e = bypass_en ? (lane_dbg_sel[l] ? dw : pw)
                    : (m_done ? norm_data[l*10 +: 10] : train_codes[m_tidx*10 +: 10]);
      q.push_back('{cyc_n, l, e, tag});
    end
    q.push_back('{cyc_n, -1, {9'b0, m_done}, tag});
    ns = m_stg;
    if (cust_load) ns = pack_custom();
    else if (sym_wr) ns[sym_wr_idx] = sym_wr_data;
    if (!bypass_en || m_idx == 3'd7) m_act = ns;
    m_stg = ns;
    m_idx = bypass_en ? m_idx + 3'd1 : 3'd0;
    if (prbs_en) begin m7 = r7[6:0]; m23 = r23[22:0]; end
    else begin m7 = '1; m23 = '1; end
    if (train_wr) begin m_tidx = train_sel; m_done = 1'b0; end
    else if (train_done_set) m_done = 1'b1;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    #1;
    while (q.size() > 0 && q[0].cyc == cyc_n) begin
      logic [9:0] got;
      cur = q.pop_front();
      got = (cur.lane < 0) ? {9'b0, train_done} : lane_sym[cur.lane*10 +: 10];
      n_run++;
      if (got !== cur.exp) begin
        n_fail++;
        $display("FAIL %s cycle %0d lane %0d got %h expected %h", cur.req, cur.cyc, cur.lane, got, cur.exp);
      end
    end
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    norm_data = 40'h12_3456_789A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc("R1"); cyc("R1");
    train_done_set = 1'b1; cyc("R2"); train_done_set = 1'b0;
    cyc("R2"); norm_data = 40'hAB_CDEF_0123; cyc("R2"); norm_data = 40'h55_AA55_AA55; cyc("R2");
    train_wr = 1'b1; train_sel = 2'd2; cyc("R3"); train_wr = 1'b0;
    cyc("R3"); cyc("R3");
    train_wr = 1'b1; train_sel = 2'd3; train_done_set = 1'b1; cyc("R3");
    train_wr = 1'b0; train_done_set = 1'b0; cyc("R3");
    train_done_set = 1'b1; cyc("R3"); train_done_set = 1'b0; cyc("R3");
    train_wr = 1'b1; train_sel = 2'd1; cyc("R3"); train_wr = 1'b0; cyc("R3");

    lane_dbg_sel = 4'hF;
    for (int i = 0; i < 8; i++) begin
      sym_wr = 1'b1; sym_wr_idx = 3'(i); sym_wr_data = 10'(10'h101 + i * 37); cyc("R4");
    end
    sym_wr = 1'b0;
    bypass_en = 1'b1;
    repeat (11) cyc("R4");
    sym_wr = 1'b1; sym_wr_idx = 3'd5; sym_wr_data = 10'h3C3; cyc("R6");
    sym_wr_idx = 3'd0; sym_wr_data = 10'h0F0; cyc("R6");
    sym_wr = 1'b0;
    repeat (14) cyc("R6");
    bypass_en = 1'b0; cyc("R4");
    bypass_en = 1'b1; repeat (4) cyc("R4");
    bypass_en = 1'b0; cyc("R4");
    bypass_en = 1'b1; repeat (10) cyc("R4");

    bypass_en = 1'b0;
    cb = '{8'h3D, 8'hC6, 8'h71, 8'h9E, 8'h04, 8'hFB, 8'h28, 8'hD5, 8'h6A, 8'h8F};
    for (int b = 0; b < 10; b++) cust_pat[b*8 +: 8] = cb[b];
    cust_load = 1'b1; sym_wr = 1'b1; sym_wr_idx = 3'd2; sym_wr_data = 10'h111; cyc("R5");
    cust_load = 1'b0; sym_wr = 1'b0;
    bypass_en = 1'b1; repeat (9) cyc("R5");
    for (int b = 0; b < 10; b++) cb[b] = 8'(b * 29 + 7);
    for (int b = 0; b < 10; b++) cust_pat[b*8 +: 8] = cb[b];
    cust_load = 1'b1; cyc("R6"); cust_load = 1'b0;
    repeat (12) cyc("R6");

    bypass_en = 1'b0;
    for (int i = 0; i < 8; i++) begin
      sym_wr = 1'b1; sym_wr_idx = 3'(i); sym_wr_data = 10'h2AA; cyc("R11");
    end
    sym_wr = 1'b0;
    bypass_en = 1'b1; repeat (10) cyc("R11");

    lane_dbg_sel = 4'h0; prbs_sel = 1'b0; cyc("R9");
    prbs_en = 1'b1; repeat (20) cyc("R7");
    prbs_en = 1'b0; repeat (3) cyc("R9");
    prbs_en = 1'b1; prbs_sel = 1'b1; repeat (20) cyc("R8");
    prbs_en = 1'b0; cyc("R9");
    prbs_en = 1'b1; prbs_sel = 1'b0; repeat (3) cyc("R9");
    lane_dbg_sel = 4'b0101; repeat (12) cyc("R10");
    prbs_sel = 1'b1; lane_dbg_sel = 4'b1010; repeat (6) cyc("R10");

    @(negedge clk); @(negedge clk);
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard got %0d pending expected 0", q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule